// File: doc/BRIEF.md
# Transmit Line Scanner

This block polls a set of transmit lines in round-robin order and tells the host which line wants its next character. While the global scan enable is high, one line is examined per clock. The scan halts on a line whose per-line enable bit is set and whose serializer reports an empty holding buffer. It then raises a ready flag, reports that line's index, and, if the interrupt enable is set, requests an interrupt.

The host responds by writing a character. The block issues a one-hot load strobe to the reported line and passes the data on to it. Scanning then resumes from the next line. Scanning also resumes if the host clears the enable bit of the line on which the scan halted. The per-line enable bits are held inside the block. They are written as one word and are cleared by reset or by a master-clear pulse.

Top module: `tx_line_scanner`

## Requirements
- R1: After a synchronous active-low reset, `tx_ready` is 0, `tx_line` is 0, `tx_irq` is 0 and `line_en` is all zeros.
- R2: A clock edge with `en_wr` high loads `en_wdata` into `line_en`, with bit i controlling line i. A clock edge with `mclr` high clears `line_en` to zero, and `mclr` takes priority over `en_wr`.
- R3: While scanning and not ready, an edge at which the examined line has both its `line_en` bit and its `tx_empty` bit set makes `tx_ready` 1 after that edge. `tx_line` then equals that line's index.
- R4: While scanning and not ready, the examined line index advances by one per clock and wraps from NUM_LINES-1 to 0. After a restart, the scan begins at the line after the one that was served.
- R5: An edge with `scan_en` low clears `tx_ready` and sets `tx_line` to 0.
- R6: While `tx_ready` is 1, a `data_wr` pulse drives `ln_load` one-hot at bit `tx_line` in the same cycle, with `ln_data` equal to `data_in`. `tx_ready` is 0 after that edge.
- R7: While `tx_ready` is 1, if the enable bit of the reported line is 0 at an edge, `tx_ready` is 0 after that edge and the scan resumes at the next line.
- R8: A `data_wr` while `tx_ready` is 0 is ignored. `ln_load` stays all zeros.
- R9: `tx_irq` is 1 exactly when `tx_ready` and `tx_int_en` are both 1.
- R10: While `tx_ready` is 1, `scan_en` is high, no data write occurs and the reported line stays enabled, `tx_ready` stays 1 and `tx_line` holds its value, whatever `tx_empty` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Global scan enable; low clears ready and line |
| mclr | input | 1 | Master-clear pulse; clears the enable bits |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | NUM_LINES | New enable bits, bit i for line i |
| tx_int_en | input | 1 | Transmit interrupt enable |
| tx_empty | input | NUM_LINES | Holding-buffer empty flags from the serializers |
| data_wr | input | 1 | Host character write strobe |
| data_in | input | DATA_W | Host character |
| line_en | output | NUM_LINES | Current enable bits |
| tx_ready | output | 1 | Scan halted on a line that needs data |
| tx_line | output | LINE_W | Index of the halted line; 0 when not ready |
| tx_irq | output | 1 | Transmit interrupt request |
| ln_load | output | NUM_LINES | One-hot load strobe to the serializers |
| ln_data | output | DATA_W | Character routed to the serializers |

## Verification
The bench builds the block with its defaults of four lines and 8-bit data. With these values LINE_W is 2, so the bench can reach the wrap from line 3 back to line 0 within a few cycles. It can also reach every enable and empty pattern across the lines. Random stimulus sparsely sets the enable bits and toggles the empty flags. This brings within reach scans that skip several idle lines, halts on the last line before the wrap, and restarts at the same edge at which another line qualifies. Directed sequences cover disable-while-ready, master clear during a halt, and writes while idle.

// File: rtl/tls_pkg.sv
// Shared helpers for the transmit line scanner.
// Assumes: line indices are unsigned and count from 0 to n-1.
package tls_pkg;

    // Width of a line index for a given line count (at least 1 bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tls_enable_reg.sv
// Per-line transmit enable bits.
// Assumes: mclr has priority over a simultaneous write; reset is synchronous.
module tls_enable_reg #(
    parameter int unsigned NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mclr,
    input  logic                 en_wr,
    input  logic [NUM_LINES-1:0] en_wdata,
    output logic [NUM_LINES-1:0] en_q
);

    // Hold the enable word; reset and master clear zero it.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

endmodule

// File: rtl/tls_scan_ctrl.sv
// Round-robin scan pointer and ready flag.
// Examines one line per clock, halts on an enabled line with an empty buffer,
// and resumes at the next line on a data write or when the halted line is disabled.
// Assumes: inputs are synchronous to clk.
module tls_scan_ctrl #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned LINE_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] tx_empty,
    input  logic                 data_wr,
    output logic                 rdy_q,
    output logic [LINE_W-1:0]    ptr_q
);

    localparam logic [LINE_W-1:0] LAST_IDX = LINE_W'(NUM_LINES - 1);

    logic [LINE_W-1:0] ptr_nxt;
    logic              cur_en;
    logic              cur_empty;

    // Next index in round-robin order, wrapping after the last line.
    always_comb begin
        ptr_nxt   = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        cur_en    = en_q[ptr_q];
        cur_empty = tx_empty[ptr_q];
    end

    // Scan state: advance, halt on a qualifying line, or restart after service.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            rdy_q <= 1'b0;
            ptr_q <= '0;
        end else if (rdy_q) begin
            if (data_wr || !cur_en) begin
                rdy_q <= 1'b0;
                ptr_q <= ptr_nxt;
            end
        end else if (cur_en && cur_empty) begin
            rdy_q <= 1'b1;
        end else begin
            ptr_q <= ptr_nxt;
        end
    end

endmodule

// File: rtl/tls_data_router.sv
// Routes a host character to the serializer of the halted line.
// Assumes: a write is accepted only while the scan is halted.
module tls_data_router #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned LINE_W    = 2,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                 rdy_q,
    input  logic [LINE_W-1:0]    ptr_q,
    input  logic                 data_wr,
    input  logic [DATA_W-1:0]    data_in,
    output logic [NUM_LINES-1:0] ln_load,
    output logic [DATA_W-1:0]    ln_data
);

    logic accept;

    // A write counts only while a line is reported.
    always_comb accept = data_wr && rdy_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_load
        // Strobe line i when it is the reported line.
        always_comb ln_load[i] = accept && (ptr_q == LINE_W'(i));
    end

    // Data is shared; the strobe selects the receiver.
    always_comb ln_data = data_in;

endmodule

// File: rtl/tx_line_scanner.sv
// Transmit line scanner top: enable bits, scan control, data routing, interrupt.
// Assumes: synchronous active-low reset; serializers sample ln_data on ln_load.
module tx_line_scanner #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned LINE_W    = tls_pkg::idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_en,
    input  logic                 mclr,
    input  logic                 en_wr,
    input  logic [NUM_LINES-1:0] en_wdata,
    input  logic                 tx_int_en,
    input  logic [NUM_LINES-1:0] tx_empty,
    input  logic                 data_wr,
    input  logic [DATA_W-1:0]    data_in,
    output logic [NUM_LINES-1:0] line_en,
    output logic                 tx_ready,
    output logic [LINE_W-1:0]    tx_line,
    output logic                 tx_irq,
    output logic [NUM_LINES-1:0] ln_load,
    output logic [DATA_W-1:0]    ln_data
);

    logic [NUM_LINES-1:0] en_q;
    logic                 rdy_q;
    logic [LINE_W-1:0]    ptr_q;

    tls_enable_reg #(.NUM_LINES(NUM_LINES)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (mclr),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .en_q     (en_q)
    );

    tls_scan_ctrl #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .en_q     (en_q),
        .tx_empty (tx_empty),
        .data_wr  (data_wr),
        .rdy_q    (rdy_q),
        .ptr_q    (ptr_q)
    );

    tls_data_router #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_route (
        .rdy_q   (rdy_q),
        .ptr_q   (ptr_q),
        .data_wr (data_wr),
        .data_in (data_in),
        .ln_load (ln_load),
        .ln_data (ln_data)
    );

    // Drive the status outputs and the interrupt request.
    always_comb begin
        line_en  = en_q;
        tx_ready = rdy_q;
        tx_line  = ptr_q;
        tx_irq   = rdy_q && tx_int_en;
    end

endmodule

// File: rtl/tls_checker.sv
// Property checker for the transmit line scanner, bound to the top module.
// Assumes: the same clock and synchronous reset as the top.
module tls_checker #(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned LINE_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scan_en,
    input logic [NUM_LINES-1:0] tx_empty,
    input logic                 data_wr,
    input logic [NUM_LINES-1:0] line_en,
    input logic                 tx_ready,
    input logic [LINE_W-1:0]    tx_line,
    input logic                 tx_irq,
    input logic [NUM_LINES-1:0] ln_load
);

    logic [NUM_LINES-1:0] qual_q;

    // Remember which lines qualified at the previous edge.
    always_ff @(posedge clk) qual_q <= line_en & tx_empty;

    AST_STOP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> qual_q[tx_line]);                               // R3
    AST_SCAN_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (!tx_ready && tx_line == '0));                         // R5
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ln_load));                                                 // R6
    AST_LOAD_TO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_load != '0) |-> ln_load[tx_line]);                              // R6
    AST_DROP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && data_wr) |=> !tx_ready);                               // R6
    AST_NO_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> (ln_load == '0));                                     // R8
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> tx_ready);                                               // R9
    AST_HOLD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && scan_en && !data_wr && line_en[tx_line])
        |=> (tx_ready && $stable(tx_line)));                                // R10

endmodule

bind tx_line_scanner tls_checker #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .tx_empty (tx_empty),
    .data_wr  (data_wr),
    .line_en  (line_en),
    .tx_ready (tx_ready),
    .tx_line  (tx_line),
    .tx_irq   (tx_irq),
    .ln_load  (ln_load)
);

// File: tb/tx_line_scanner_tb_top.sv
// Self-checking bench: reference model built from the requirements, random plus directed stimulus.
module tx_line_scanner_tb_top;

    localparam int CLK_P  = 10;
    localparam int NL     = 4;
    localparam int DW     = 8;
    localparam int LW     = 2;
    localparam int N_RAND = 6000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scan_en, mclr, en_wr, tx_int_en, data_wr;
    logic [NL-1:0] en_wdata, tx_empty;
    logic [DW-1:0] data_in;
    logic [NL-1:0] line_en, ln_load;
    logic          tx_ready, tx_irq;
    logic [LW-1:0] tx_line;
    logic [DW-1:0] ln_data;

    int checks   = 0;
    int failures = 0;

    // Reference state.
    logic          m_rdy;
    logic [LW-1:0] m_ptr;
    logic [NL-1:0] m_en;

    always #(CLK_P/2) clk = ~clk;

    tx_line_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mclr(mclr),
        .en_wr(en_wr), .en_wdata(en_wdata), .tx_int_en(tx_int_en),
        .tx_empty(tx_empty), .data_wr(data_wr), .data_in(data_in),
        .line_en(line_en), .tx_ready(tx_ready), .tx_line(tx_line),
        .tx_irq(tx_irq), .ln_load(ln_load), .ln_data(ln_data)
    );

    function automatic logic [LW-1:0] next_idx(input logic [LW-1:0] p);
        return (p == LW'(NL-1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [NL-1:0] exp_load(input logic r, input logic [LW-1:0] p,
                                               input logic w);
        return (r && w) ? (NL'(1) << p) : '0;
    endfunction

    // Reference model update from the requirement text.
    always @(posedge clk) begin
        if (!rst_n || mclr) m_en <= '0;
        else if (en_wr) m_en <= en_wdata;
        if (!rst_n || !scan_en) begin
            m_rdy <= 1'b0; m_ptr <= '0;
        end else if (m_rdy) begin
            if (data_wr || !m_en[m_ptr]) begin m_rdy <= 1'b0; m_ptr <= next_idx(m_ptr); end
        end else if (m_en[m_ptr] && tx_empty[m_ptr]) begin
            m_rdy <= 1'b1;
        end else begin
            m_ptr <= next_idx(m_ptr);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare the registered outputs (called at the falling edge).
    task automatic chk_state();
        chk("R3", "tx_ready", int'(tx_ready), int'(m_rdy));
        chk("R4", "tx_line", int'(tx_line), int'(m_ptr));
        chk("R9", "tx_irq", int'(tx_irq), int'(m_rdy && tx_int_en));
        chk("R2", "line_en", int'(line_en), int'(m_en));
    endtask

    // Compare the combinational routing after the inputs settle.
    task automatic chk_route();
        chk(m_rdy ? "R6" : "R8", "ln_load", int'(ln_load), int'(exp_load(m_rdy, m_ptr, data_wr)));
        if (ln_load != '0) chk("R6", "ln_data", int'(ln_data), int'(data_in));
    endtask

    // One cycle: check state, apply inputs, check routing, pass the edge.
    task automatic step(input logic se, input logic mc, input logic ew, input logic [NL-1:0] ed,
                        input logic ie, input logic [NL-1:0] em, input logic dw,
                        input logic [DW-1:0] d);
        @(negedge clk);
        chk_state();
        scan_en = se; mclr = mc; en_wr = ew; en_wdata = ed;
        tx_int_en = ie; tx_empty = em; data_wr = dw; data_in = d;
        #1;
        chk_route();
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7781));
        rst_n = 1'b0; scan_en = 1'b1; mclr = 1'b0; en_wr = 1'b1; en_wdata = '1;
        tx_int_en = 1'b1; tx_empty = '1; data_wr = 1'b0; data_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, with inputs that would otherwise set things.
        chk("R1", "tx_ready", int'(tx_ready), 0);
        chk("R1", "tx_line", int'(tx_line), 0);
        chk("R1", "tx_irq", int'(tx_irq), 0);
        chk("R1", "line_en", int'(line_en), 0);
        rst_n = 1'b1; en_wr = 1'b0;

        // R2/R3/R4: enable only line 2; halt there after examining 0,1,2.
        step(1, 0, 1, 4'b0100, 1, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 1, 4'b0000, 0, 8'h00);
        chk("R3", "halt on line 2", int'(tx_ready), 1);
        chk("R4", "line 2 reported", int'(tx_line), 2);
        // R10: empty drops but halt holds.
        step(1, 0, 0, 4'b0000, 1, 4'b0000, 0, 8'h00);
        // R6: write routes to line 2.
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 1, 8'hA5);
        chk("R6", "load strobe line 2", int'(ln_load), 4);
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        chk("R6", "ready cleared after write", int'(tx_ready), 0);
        // R4: resumes at line 3 then 0,1,2.
        chk("R4", "resume at line 3", int'(tx_line), 3);
        // R8: write while idle is ignored.
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 1, 8'h3C);
        chk("R8", "no load while idle", int'(ln_load), 0);
        repeat (4) step(1, 0, 0, 4'b0000, 0, 4'b1111, 0, 8'h00);
        // R7: disable the halted line; scan resumes.
        step(1, 0, 1, 4'b0000, 0, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 0, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 0, 4'b1111, 0, 8'h00);
        chk("R7", "ready drops after disable", int'(tx_ready), 0);
        // R5: scan off clears ready and line.
        step(1, 0, 1, 4'b1000, 1, 4'b1111, 0, 8'h00);
        repeat (6) step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        step(0, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        chk("R5", "ready cleared by scan off", int'(tx_ready), 0);
        chk("R5", "line cleared by scan off", int'(tx_line), 0);
        // R2: master clear beats a write.
        step(1, 1, 1, 4'b1111, 1, 4'b1111, 0, 8'h00);
        step(1, 0, 0, 4'b0000, 1, 4'b1111, 0, 8'h00);
        chk("R2", "mclr priority", int'(line_en), 0);

        // Random phase.
        for (int i = 0; i < N_RAND; i++) begin
            logic se, mc, ew, ie, dw;
            se = ($urandom % 40) != 0;
            mc = ($urandom % 200) == 0;
            ew = ($urandom % 12) == 0;
            ie = ($urandom % 4) != 0;
            dw = ($urandom % 3) == 0;
            step(se, mc, ew, NL'($urandom & $urandom), ie, NL'($urandom), dw, DW'($urandom));
        end
        @(negedge clk);
        chk_state();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule